// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block is the register front end of a level-2 cache controller that carries out maintenance over a range of physical addresses. Software first writes the start address of the range to a base register. It then writes the inclusive address of the last line to one of three command registers. The register chosen selects invalidate, clean, or clean-and-invalidate (flush). The engine then walks the range one 32-byte line at a time. For each line it raises a request, made of an opcode and a line address, on a valid/ready port that leads to the tag and data arrays.

A range must lie inside one 4 KiB page. The reason is that the cache resolves only the start address. A range that leaves the page, or that ends below its start, is refused: a sticky error flag is set and no line request is issued. Software polls a sync register after each command. Bit 0 of that register reads 1 while a walk is in progress. A second command written during a walk is held off by dropping write-ready until the walk ends.

Top module: `cache_range_engine`

## Requirements
- R1: After reset, no line request is raised, the sync register (offset 0x700) reads 0, and the base register (offset 0x720) reads 0.
- R2: A write to offset 0x720 stores the base address with its low 5 bits forced to 0, and a read of 0x720 returns that stored value.
- R3: An accepted write of an end address to offset 0x774 starts an invalidate walk (opcode 2'b01). A write to 0x7b4 starts a clean walk (opcode 2'b10), and a write to 0x7f4 starts a flush walk (opcode 2'b11). The first request is raised in the cycle after the write is accepted, and its address is the stored base.
- R4: Each acknowledged request (valid and ready both high at a clock edge) advances the line address by 32. The walk ends after the request for the end line is acknowledged, so exactly (end-base)/32+1 requests are issued, in ascending order.
- R5: While a request is not acknowledged, valid stays high and the address and opcode hold steady.
- R6: Bit 0 of the sync register reads 1 from the cycle after a walk starts until the last request has been acknowledged, and reads 0 afterwards.
- R7: An end address in a different 4 KiB page (address bits above 11) from the base sets the error flag, bit 1 of the sync register, and no request is issued. The error flag stays set through later legal commands.
- R8: An end address below the base in the same page is refused in the same way as in R7.
- R9: Any write to offset 0x700 clears the error flag.
- R10: While a walk is in progress, a write to any of the three command offsets sees write-ready low. The write is accepted only after the walk has ended.
- R11: A write to the base register during a walk is accepted at once and does not change the walk in progress. The next command uses the new base.
- R12: The low 5 bits of the end address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted at this edge when valid is also high |
| wr_addr | input | OFF_W | Register write offset |
| wr_data | input | ADDR_W | Register write data |
| rd_addr | input | OFF_W | Register read offset |
| rd_data | output | ADDR_W | Read data (combinational) |
| ln_valid | output | 1 | Per-line request valid |
| ln_ready | input | 1 | Per-line request acknowledge |
| ln_op | output | 2 | Per-line opcode: 01 invalidate, 10 clean, 11 flush |
| ln_addr | output | ADDR_W | Line-aligned address of the request |

## Verification
Random commands are tried with random bases, random lengths of up to a page, and unaligned low bits. These show whether the walk order, the inclusive end, and the alignment are right. Ranges that cross a page or run backwards are mixed in, to separate refusal from execution. Each run is driven with three acknowledge patterns: always ready, random ready, and long stalls. These show whether a request holds steady under back-pressure. A directed stall case checks that a command written mid-walk waits for the walk to end and that a base write during the walk is accepted without disturbing it.

// File: rtl/cache_range_engine.sv
module cache_range_engine #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 12,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [OFF_W-1:0]  wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_addr,
  output logic [ADDR_W-1:0] rd_data,
  output logic              ln_valid,
  input  logic              ln_ready,
  output logic [1:0]        ln_op,
  output logic [ADDR_W-1:0] ln_addr
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam logic [OFF_W-1:0] OFF_SYNC = OFF_W'(12'h700);
  localparam logic [OFF_W-1:0] OFF_BASE = OFF_W'(12'h720);
  localparam logic [OFF_W-1:0] OFF_INV  = OFF_W'(12'h774);
  localparam logic [OFF_W-1:0] OFF_CLN  = OFF_W'(12'h7b4);
  localparam logic [OFF_W-1:0] OFF_FLS  = OFF_W'(12'h7f4);

  logic [ADDR_W-1:0] base_q, cur_q, last_q;
  logic [1:0]        op_q, op_sel;
  logic              busy_q, err_q;

  wire [ADDR_W-1:0] data_ln = {wr_data[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}};
  wire is_cmd  = (wr_addr == OFF_INV) || (wr_addr == OFF_CLN) || (wr_addr == OFF_FLS);
  wire bad_rng = (data_ln[ADDR_W-1:PAGE_SH] != base_q[ADDR_W-1:PAGE_SH]) || (data_ln < base_q);

  assign wr_ready = !(busy_q && is_cmd);
  wire   wr_fire  = wr_valid && wr_ready;

  always_comb begin
    case (wr_addr)
      OFF_INV: op_sel = 2'b01;
      OFF_CLN: op_sel = 2'b10;
      default: op_sel = 2'b11;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
      last_q <= '0;
      op_q   <= 2'b00;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_fire && wr_addr == OFF_BASE) base_q <= data_ln;
      if (wr_fire && wr_addr == OFF_SYNC) err_q <= 1'b0;
      if (wr_fire && is_cmd) begin
        if (bad_rng) err_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          cur_q  <= base_q;
          last_q <= data_ln;
          op_q   <= op_sel;
        end
      end else if (busy_q && ln_ready) begin
        if (cur_q == last_q) busy_q <= 1'b0;
        else cur_q <= cur_q + ADDR_W'(LINE_BYTES);
      end
    end
  end

  assign ln_valid = busy_q;
  assign ln_addr  = cur_q;
  assign ln_op    = op_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFF_SYNC) rd_data[1:0] = {err_q, busy_q};
    else if (rd_addr == OFF_BASE) rd_data = base_q;
  end
endmodule

// File: rtl/cache_range_engine_chk.sv
module cache_range_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 12,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [OFF_W-1:0]  wr_addr,
  input logic [OFF_W-1:0]  rd_addr,
  input logic [ADDR_W-1:0] rd_data,
  input logic              ln_valid,
  input logic              ln_ready,
  input logic [1:0]        ln_op,
  input logic [ADDR_W-1:0] ln_addr
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid && !ln_ready |=> ln_valid && $stable(ln_addr) && $stable(ln_op));

  a_r4_step_line: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid && ln_ready |=> !ln_valid || (ln_addr == $past(ln_addr) + ADDR_W'(LINE_BYTES)));

  a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid && $past(ln_valid) |-> ln_addr[ADDR_W-1:PAGE_SH] == $past(ln_addr[ADDR_W-1:PAGE_SH]));

  a_r3_legal_op: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid |-> ln_op != 2'b00);

  a_r12_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid |-> ln_addr[LINE_SH-1:0] == '0);

  a_r10_stall_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid && wr_valid && (wr_addr == OFF_W'(12'h774) || wr_addr == OFF_W'(12'h7b4)
      || wr_addr == OFF_W'(12'h7f4)) |-> !wr_ready);

  a_r6_sync_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == OFF_W'(12'h700) |-> rd_data[0] == ln_valid);
endmodule

bind cache_range_engine cache_range_engine_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .ln_valid(ln_valid), .ln_ready(ln_ready),
  .ln_op(ln_op), .ln_addr(ln_addr)
);

// File: tb/tb_cache_range_engine.sv
module tb_cache_range_engine;
  localparam logic [11:0] A_SYNC = 12'h700, A_BASE = 12'h720;
  localparam logic [11:0] A_INV = 12'h774, A_CLN = 12'h7b4, A_FLS = 12'h7f4;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, ln_ready = 0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic wr_ready, ln_valid;
  logic [31:0] rd_data, ln_addr;
  logic [1:0] ln_op;

  cache_range_engine dut (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_op(ln_op), .ln_addr(ln_addr));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int rmode = 1;
  logic [31:0] got_a[$], exp_a[$];
  logic [1:0]  got_o[$], exp_o[$];
  logic [31:0] base_m = 0;
  bit err_m = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit prev_stall = 0;
  logic [31:0] prev_a;
  logic [1:0]  prev_o;
  always @(negedge clk) begin
    logic r;
    if (prev_stall) chk(ln_valid && ln_addr == prev_a && ln_op == prev_o, "R5", ln_addr, prev_a);
    r = (rmode == 1) ? 1'b1 : (rmode == 2) ? 1'($urandom_range(0, 1)) : 1'b0;
    ln_ready = r;
    if (ln_valid && r) begin got_a.push_back(ln_addr); got_o.push_back(ln_op); end
    prev_stall = ln_valid && !r;
    prev_a = ln_addr; prev_o = ln_op;
  end

  function automatic logic [1:0] op_of(input logic [11:0] a);
    return (a == A_INV) ? 2'b01 : (a == A_CLN) ? 2'b10 : 2'b11;
  endfunction

  function automatic bit predict(input logic [31:0] e, input logic [11:0] a);
    logic [31:0] el = {e[31:5], 5'b0};
    if (el[31:12] != base_m[31:12] || el < base_m) return 1;
    for (logic [31:0] x = base_m; x <= el; x += 32) begin
      exp_a.push_back(x); exp_o.push_back(op_of(a));
    end
    return 0;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d; #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    rd(A_SYNC, s);
    while (s[0]) begin @(negedge clk); rd(A_SYNC, s); end
  endtask

  task automatic compare(input string req);
    chk(got_a.size() == exp_a.size(), req, got_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++)
      chk(got_a[i] == exp_a[i] && got_o[i] == exp_o[i], req, {got_o[i], got_a[i][29:0]},
          {exp_o[i], exp_a[i][29:0]});
    got_a.delete(); got_o.delete(); exp_a.delete(); exp_o.delete();
  endtask

  task automatic run_cmd(input logic [31:0] b, input logic [31:0] e, input logic [11:0] a, input string req);
    logic [31:0] s;
    bit bad;
    wr(A_BASE, b); base_m = {b[31:5], 5'b0};
    bad = predict(e, a);
    if (bad) err_m = 1;
    wr(a, e);
    rd(A_SYNC, s);
    if (!bad) chk(s[0] == 1'b1 || got_a.size() > 0, "R6", s, 1);
    wait_idle();
    compare(req);
    rd(A_SYNC, s);
    chk(s[1:0] == {err_m, 1'b0}, bad ? "R7" : "R6", s, {err_m, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(!ln_valid, "R1", ln_valid, 0);
    rd(A_SYNC, s); chk(s == 0, "R1", s, 0);
    rd(A_BASE, s); chk(s == 0, "R1", s, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!ln_valid, "R1", ln_valid, 0);

    wr(A_BASE, 32'h1234_567f); base_m = 32'h1234_5660;
    rd(A_BASE, s); chk(s == 32'h1234_5660, "R2", s, 32'h1234_5660);

    run_cmd(32'h0000_1000, 32'h0000_1000, A_INV, "R3");
    run_cmd(32'h0000_2040, 32'h0000_20bf, A_CLN, "R4");
    run_cmd(32'h0000_3fe0, 32'h0000_3fff, A_FLS, "R12");
    run_cmd(32'h0000_3000, 32'h0000_3fe0, A_INV, "R4");
    rmode = 2;
    run_cmd(32'h0000_5fe0, 32'h0000_6000, A_CLN, "R7");
    run_cmd(32'h0000_7100, 32'h0000_7000, A_FLS, "R8");
    run_cmd(32'h0000_8000, 32'h0000_8040, A_INV, "R7");
    wr(A_SYNC, 0); err_m = 0;
    rd(A_SYNC, s); chk(s == 0, "R9", s, 0);

    rmode = 0;
    wr(A_BASE, 32'h0000_9000); base_m = 32'h0000_9000;
    void'(predict(32'h0000_90e0, A_CLN));
    wr(A_CLN, 32'h0000_90e0);
    wr(A_BASE, 32'h0000_a020); base_m = 32'h0000_a020;
    rd(A_BASE, s); chk(s == 32'h0000_a020, "R11", s, 32'h0000_a020);
    @(negedge clk); wr_valid = 1; wr_addr = A_FLS; wr_data = 32'h0000_a060; #1;
    for (int i = 0; i < 5; i++) begin
      chk(!wr_ready, "R10", wr_ready, 0);
      @(negedge clk); #1;
    end
    void'(predict(32'h0000_a060, A_FLS));
    rmode = 1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk); wr_valid = 0;
    wait_idle();
    compare("R11");

    for (int k = 0; k < 40; k++) begin
      logic [31:0] b, e;
      int m;
      rmode = $urandom_range(1, 2);
      b = $urandom;
      m = $urandom_range(0, 9);
      if (m == 0) e = b + 32'h1000;
      else if (m == 1) e = {b[31:5], 5'b0} - 32'd32;
      else e = b + $urandom_range(0, 4095);
      if (m == 1 && b[11:5] == 0) e = b + 32'h1000;
      run_cmd(b, e, (k % 3 == 0) ? A_INV : (k % 3 == 1) ? A_CLN : A_FLS, "R4");
      if (err_m) begin wr(A_SYNC, 0); err_m = 0; end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule